// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames into memory by walking a circular list of receive descriptors. Each descriptor is 16 bytes long and holds a 64-bit control word (low word first) followed by a 32-bit buffer address. The engine stays idle until it is started by a poll pulse or by its own poll timer. It then reads a descriptor and checks that hardware owns it. It stores the incoming frame bytes into that descriptor's buffer. Finally it writes the result into the low control word and hands the descriptor back to software. After the written-back descriptor it moves on to the next one, either 16 bytes further along or back to the ring base when the current descriptor carries the end-of-ring flag.

The state machine has eight states:

- IDLE: waits for the first poll, then loads the ring base.
- FETCH_LO, FETCH_HI, FETCH_BUF: read the three descriptor words, one read per cycle, with read data returned one cycle later.
- CHECK: decides between STALL (software owns the descriptor), WBACK (the buffer address is invalid) and RECV (everything else).
- RECV: takes frame bytes and goes to WBACK on the last byte.
- WBACK: writes the status and advances the pointer, then goes to FETCH_LO.
- STALL: signals that no buffer is available, discards frames, and goes to FETCH_LO on the next poll.

Memory is a simple word port with byte enables and a read latency of one cycle.

Top module: `rxr_ring_engine`

## Requirements
- R1: After reset the engine is idle: no memory request, `frm_ready` low, `rx_nobuf` low, and it stays so until a poll arrives.
- R2: The first poll starts at `ring_base`. The engine then reads byte addresses base, base+4 and base+8 in three consecutive cycles, and every read address is word aligned.
- R3: A descriptor with control bit 31 clear is owned by software. The engine writes nothing for it and raises `rx_nobuf`. While `rx_nobuf` is high, frames are accepted and discarded. `rx_nobuf` stays high until the next poll (manual or automatic), and it drops in the cycle after that poll.
- R4: Frame byte i is written to buffer address + i. Each byte write uses the word address, a single byte enable selected by byte address bits 1:0, and the byte copied into all four lanes.
- R5: After a frame, the low control word is written with all enables set, as follows:
  - bit 31 cleared;
  - bits 29 and 28 set (first and last);
  - bits 10:0 set to the number of bytes stored.
- R6: Bit 17 is set when the first six bytes are all 0xFF. Otherwise bit 16 is set when bit 0 of the first byte is 1.
- R7: Bit 19 copies `frm_err` on the last byte. Bit 21 is set when the frame is shorter than RUNT_MIN bytes. Bit 20 is set when the frame exceeds the buffer size held in bits 42:32 (high word bits 10:0); in that case only the first buffer-size bytes are stored.
- R8: A buffer address whose bits 1:0 are not 2'b10 is rejected. The descriptor is written back with only bit 18 set (length 0, owner cleared), no byte is written and no frame byte is taken.
- R9: After write-back the engine fetches the descriptor 16 bytes further on. If control bit 63 (high word bit 31) was set, it fetches at `ring_base` instead.
- R10: While stalled, with `poll_ivl` = n > 0, an automatic poll ends each stall after exactly n*TICK_CYCLES cycles. With n = 0 the engine never polls itself.
- R11: `frm_ready` is low during descriptor fetches and write-back, and high only in RECV and STALL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_base | input | AW | Byte address of the first descriptor |
| poll_wr | input | 1 | Poll-demand pulse |
| poll_ivl | input | IVL_W | Automatic poll interval in timer units, 0 = off |
| frm_valid | input | 1 | Frame byte present |
| frm_data | input | 8 | Frame byte |
| frm_last | input | 1 | Byte is the last of the frame |
| frm_err | input | 1 | Frame error flag, sampled with the last byte |
| frm_ready | output | 1 | Engine takes the byte this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| rx_nobuf | output | 1 | No receive buffer available (stalled) |

## Verification
The assertions check several rules on every cycle:
- write-backs always clear the owner bit;
- byte writes carry one enable and a replicated byte;
- reads are word aligned and never overlap with `frm_ready`;
- a rejected-buffer write-back carries no length or frame flags;
- `rx_nobuf` cannot fall without a poll and never coexists with a write.

Only the bench scenarios can show where the bytes land and what status values are written. The same holds for ring wrap versus linear advance, the dropping of frames while stalled, and the exact length of the automatic poll interval. For these, the bench sweeps frame lengths from 1 to 80 across the buffer-size and runt boundaries.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_LO,
        ST_FETCH_HI,
        ST_FETCH_BUF,
        ST_CHECK,
        ST_RECV,
        ST_WBACK,
        ST_STALL
    } rxr_state_e;

    // low control word bit positions
    localparam int OWN_BIT    = 31;
    localparam int FIRST_BIT  = 29;
    localparam int LAST_BIT   = 28;
    localparam int RUNT_BIT   = 21;
    localparam int FTL_BIT    = 20;
    localparam int CRC_BIT    = 19;
    localparam int BUSERR_BIT = 18;
    localparam int BCAST_BIT  = 17;
    localparam int MCAST_BIT  = 16;
    // high control word bit positions
    localparam int RING_END_BIT = 31;
    localparam int DESC_BYTES   = 16;
    localparam int DA_BYTES     = 6;
endpackage

// File: rtl/rxr_poll_timer.sv
module rxr_poll_timer #(
    parameter int TICK_CYCLES = 16,
    parameter int IVL_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [IVL_W-1:0] ivl,
    output logic             fire
);
    localparam int TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

    logic [TW-1:0]    tick_q;
    logic [IVL_W-1:0] unit_q;
    logic             tick_end;

    assign tick_end = (tick_q == TW'(TICK_CYCLES - 1));
    assign fire     = run && (ivl != '0) && tick_end && (unit_q == ivl - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
            unit_q <= '0;
        end else if (!run || fire) begin
            tick_q <= '0;
            unit_q <= '0;
        end else if (tick_end) begin
            tick_q <= '0;
            unit_q <= unit_q + 1'b1;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end
endmodule

// File: rtl/rxr_frame_track.sv
module rxr_frame_track import rxr_pkg::*; #(
    parameter int LEN_W    = 11,
    parameter int RUNT_MIN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take,
    input  logic [7:0]       data,
    input  logic             last,
    input  logic             err,
    input  logic [LEN_W-1:0] bufsz,
    output logic [LEN_W:0]   idx,
    output logic             store_en,
    output logic [31:0]      status
);
    logic [LEN_W:0]   idx_q;
    logic             bc_q, mc_q, crc_q;
    logic             too_long, bcast;
    logic [LEN_W-1:0] stored;

    assign idx      = idx_q;
    assign too_long = idx_q > {1'b0, bufsz};
    assign store_en = !too_long && (idx_q != {1'b0, bufsz});
    assign stored   = too_long ? bufsz : idx_q[LEN_W-1:0];
    assign bcast    = bc_q && (idx_q >= (LEN_W+1)'(DA_BYTES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            bc_q  <= 1'b1;
            mc_q  <= 1'b0;
            crc_q <= 1'b0;
        end else if (clr) begin
            idx_q <= '0;
            bc_q  <= 1'b1;
            mc_q  <= 1'b0;
            crc_q <= 1'b0;
        end else if (take) begin
            if (idx_q != '1)
                idx_q <= idx_q + 1'b1;
            if (idx_q < (LEN_W+1)'(DA_BYTES) && data != 8'hFF)
                bc_q <= 1'b0;
            if (idx_q == '0)
                mc_q <= data[0];
            if (last)
                crc_q <= err;
        end
    end

    always_comb begin
        status              = '0;
        status[LEN_W-1:0]   = stored;
        status[FIRST_BIT]   = 1'b1;
        status[LAST_BIT]    = 1'b1;
        status[BCAST_BIT]   = bcast;
        status[MCAST_BIT]   = mc_q && !bcast;
        status[CRC_BIT]     = crc_q;
        status[FTL_BIT]     = too_long;
        status[RUNT_BIT]    = idx_q < (LEN_W+1)'(RUNT_MIN);
    end
endmodule

// File: rtl/rxr_ring_engine.sv
module rxr_ring_engine import rxr_pkg::*; #(
    parameter int AW          = 16,
    parameter int LEN_W       = 11,
    parameter int RUNT_MIN    = 64,
    parameter int TICK_CYCLES = 16,
    parameter int IVL_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    ring_base,
    input  logic             poll_wr,
    input  logic [IVL_W-1:0] poll_ivl,
    input  logic             frm_valid,
    input  logic [7:0]       frm_data,
    input  logic             frm_last,
    input  logic             frm_err,
    output logic             frm_ready,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [3:0]       mem_be,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    output logic             rx_nobuf
);
    rxr_state_e state_q, state_d;

    logic [AW-1:0]    desc_q, buf_q, byte_addr;
    logic [LEN_W-1:0] bsz_q;
    logic             own_q, end_q, skip_q;
    logic             auto_fire, poll_go, buf_ok;
    logic             trk_clr, trk_take, store_en;
    logic [LEN_W:0]   idx;
    logic [31:0]      status;

    assign poll_go   = poll_wr || auto_fire;
    assign buf_ok    = (mem_rdata[1:0] == 2'b10);
    assign trk_clr   = (state_q == ST_CHECK);
    assign trk_take  = (state_q == ST_RECV) && frm_valid;
    assign byte_addr = buf_q + AW'(idx);

    rxr_poll_timer #(.TICK_CYCLES(TICK_CYCLES), .IVL_W(IVL_W)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  ((state_q == ST_STALL) || (state_q == ST_IDLE)),
        .ivl  (poll_ivl),
        .fire (auto_fire)
    );

    rxr_frame_track #(.LEN_W(LEN_W), .RUNT_MIN(RUNT_MIN)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (trk_clr),
        .take    (trk_take),
        .data    (frm_data),
        .last    (frm_last),
        .err     (frm_err),
        .bufsz   (bsz_q),
        .idx     (idx),
        .store_en(store_en),
        .status  (status)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // descriptor context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_q <= '0;
            buf_q  <= '0;
            bsz_q  <= '0;
            own_q  <= 1'b0;
            end_q  <= 1'b0;
            skip_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE:      if (poll_go) desc_q <= ring_base;
                ST_FETCH_HI:  own_q <= mem_rdata[OWN_BIT];
                ST_FETCH_BUF: begin
                    end_q <= mem_rdata[RING_END_BIT];
                    bsz_q <= mem_rdata[LEN_W-1:0];
                end
                ST_CHECK: begin
                    buf_q  <= mem_rdata[AW-1:0];
                    skip_q <= !buf_ok;
                end
                ST_WBACK:     desc_q <= end_q ? ring_base : desc_q + AW'(DESC_BYTES);
                default: ;
            endcase
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (poll_go) state_d = ST_FETCH_LO;
            ST_FETCH_LO:  state_d = ST_FETCH_HI;
            ST_FETCH_HI:  state_d = ST_FETCH_BUF;
            ST_FETCH_BUF: state_d = ST_CHECK;
            ST_CHECK: begin
                if (!own_q)       state_d = ST_STALL;
                else if (!buf_ok) state_d = ST_WBACK;
                else              state_d = ST_RECV;
            end
            ST_RECV:      if (frm_valid && frm_last) state_d = ST_WBACK;
            ST_WBACK:     state_d = ST_FETCH_LO;
            ST_STALL:     if (poll_go) state_d = ST_FETCH_LO;
        endcase
    end

    // outputs
    always_comb begin
        frm_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_q;
        mem_be    = 4'h0;
        mem_wdata = '0;
        rx_nobuf  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_CHECK: ;
            ST_FETCH_LO:  mem_req = 1'b1;
            ST_FETCH_HI: begin
                mem_req  = 1'b1;
                mem_addr = desc_q + AW'(4);
            end
            ST_FETCH_BUF: begin
                mem_req  = 1'b1;
                mem_addr = desc_q + AW'(8);
            end
            ST_RECV: begin
                frm_ready = 1'b1;
                if (frm_valid && store_en) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = {byte_addr[AW-1:2], 2'b00};
                    mem_be    = 4'b0001 << byte_addr[1:0];
                    mem_wdata = {4{frm_data}};
                end
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_be    = 4'hF;
                mem_wdata = skip_q ? (32'h1 << BUSERR_BIT) : status;
            end
            ST_STALL: begin
                frm_ready = 1'b1;
                rx_nobuf  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/rxr_ring_checker.sv
module rxr_ring_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [3:0]    mem_be,
    input logic [31:0]   mem_wdata,
    input logic          frm_ready,
    input logic          rx_nobuf,
    input logic          poll_go
);
    AST_OWNER_RETURNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be == 4'hF) |-> !mem_wdata[31]); // R5

    AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be != 4'hF) |-> ($countones(mem_be) == 1 && mem_addr[1:0] == 2'b00)); // R4

    AST_BYTE_REPLICATED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be != 4'hF) |->
        (mem_wdata[7:0] == mem_wdata[15:8] && mem_wdata[15:8] == mem_wdata[23:16]
         && mem_wdata[23:16] == mem_wdata[31:24])); // R4

    AST_READ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (mem_addr[1:0] == 2'b00)); // R2

    AST_NO_READY_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> !frm_ready); // R11

    AST_NOBUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_nobuf && !poll_go) |=> rx_nobuf); // R3

    AST_NOBUF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_nobuf |-> !(mem_req && mem_we)); // R3

    AST_REJECT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be == 4'hF && mem_wdata[18]) |->
        (mem_wdata[10:0] == 11'd0 && !mem_wdata[29] && !mem_wdata[28])); // R8
endmodule

bind rxr_ring_engine rxr_ring_checker #(.AW(AW)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_be   (mem_be),
    .mem_wdata(mem_wdata),
    .frm_ready(frm_ready),
    .rx_nobuf (rx_nobuf),
    .poll_go  (poll_go)
);

// File: tb/test_rxr_ring_engine.sv
`timescale 1ns/1ps
module test_rxr_ring_engine;
    localparam int AW   = 16;
    localparam int TICK = 4;
    localparam int BASE = 'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [AW-1:0] ring_base = AW'(BASE);
    logic        poll_wr = 1'b0;
    logic [3:0]  poll_ivl = 4'd0;
    logic        frm_valid = 1'b0, frm_last = 1'b0, frm_err = 1'b0;
    logic [7:0]  frm_data = 8'h00;
    logic        frm_ready, mem_req, mem_we, rx_nobuf;
    logic [AW-1:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [31:0] mem [0:511];

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    rxr_ring_engine #(.AW(AW), .TICK_CYCLES(TICK)) i_rxr_ring_engine (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .poll_wr(poll_wr),
        .poll_ivl(poll_ivl), .frm_valid(frm_valid), .frm_data(frm_data),
        .frm_last(frm_last), .frm_err(frm_err), .frm_ready(frm_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rx_nobuf(rx_nobuf)
    );

    // memory model: one-cycle read latency, byte-enable writes
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[10:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[10:2]];
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    function automatic logic [7:0] fbyte(int len, int i);
        if (len % 5 == 0 && i < 6) return 8'hFF;
        if (i == 0) return (len % 3 == 0) ? 8'h33 : 8'h42;
        return 8'((len * 7 + i * 13) & 255);
    endfunction

    function automatic logic [31:0] exp_stat(int len, int bsz, bit e);
        logic [31:0] r;
        int st;
        bit bc, mc;
        st = (len > bsz) ? bsz : len;
        bc = (len % 5 == 0) && (len >= 6);
        mc = !bc && fbyte(len, 0)[0];
        r = 32'(st);
        r[16] = mc; r[17] = bc; r[19] = e;
        r[20] = (len > bsz); r[21] = (len < 64);
        r[28] = 1'b1; r[29] = 1'b1;
        return r;
    endfunction

    function automatic logic [7:0] get_byte(int a);
        return mem[a >> 2][8*(a % 4) +: 8];
    endfunction

    task automatic set_desc(int a, bit own, bit ende, int bsz, int bufa);
        mem[a/4 + 0] = {own, 31'd0};
        mem[a/4 + 1] = {ende, 20'd0, 11'(bsz)};
        mem[a/4 + 2] = 32'(bufa);
        mem[a/4 + 3] = 32'd0;
    endtask

    task automatic fill(int lo, int hi);
        for (int w = lo / 4; w < hi / 4; w++) mem[w] = 32'hA5A5A5A5;
    endtask

    task automatic do_poll();
        poll_wr = 1'b1;
        @(negedge clk);
        poll_wr = 1'b0;
    endtask

    task automatic send_frame(int len, bit e);
        for (int i = 0; i < len; i++) begin
            frm_valid = 1'b1;
            frm_data  = fbyte(len, i);
            frm_last  = (i == len - 1);
            frm_err   = e && (i == len - 1);
            while (!frm_ready) @(negedge clk);
            @(negedge clk);
        end
        frm_valid = 1'b0;
        frm_last  = 1'b0;
        frm_err   = 1'b0;
    endtask

    task automatic check_buf(string req, int bufa, int len, int bsz);
        int st;
        int bad;
        st  = (len > bsz) ? bsz : len;
        bad = 0;
        for (int i = 0; i < st; i++) if (get_byte(bufa + i) !== fbyte(len, i)) bad++;
        check(req, 32'(bad), 32'd0);
        check(req, {24'd0, get_byte(bufa + st)}, 32'h000000A5);
    endtask

    initial begin
        for (int w = 0; w < 512; w++) mem[w] = 32'd0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 mem_req", {31'd0, mem_req}, 32'd0);
        check("R1 frm_ready", {31'd0, frm_ready}, 32'd0);
        check("R1 rx_nobuf", {31'd0, rx_nobuf}, 32'd0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check("R1 idle without poll", {30'd0, mem_req, frm_ready}, 32'd0);

        // directed ring: D0 ok, D1 small buffer, D2 bad address, D3 end of ring
        fill('h100, 'h600);
        set_desc(BASE + 'h00, 1, 0, 100, 'h102);
        set_desc(BASE + 'h10, 1, 0, 20, 'h202);
        set_desc(BASE + 'h20, 1, 0, 100, 'h300);
        set_desc(BASE + 'h30, 1, 1, 100, 'h402);
        set_desc(BASE + 'h40, 1, 0, 100, 'h502); // decoy, reached only without wrap
        do_poll();
        // R2 / R11: fetch sequence
        check("R2 read base", {mem_req, mem_we, 14'd0, mem_addr}, {2'b10, 14'd0, 16'(BASE)});
        check("R11 ready low in fetch", {31'd0, frm_ready}, 32'd0);
        @(negedge clk);
        check("R2 read base+4", {mem_req, mem_we, 14'd0, mem_addr}, {2'b10, 14'd0, 16'(BASE + 4)});
        @(negedge clk);
        check("R2 read base+8", {mem_req, mem_we, 14'd0, mem_addr}, {2'b10, 14'd0, 16'(BASE + 8)});

        send_frame(70, 0);
        send_frame(33, 0);
        send_frame(10, 1);
        repeat (10) @(negedge clk);
        check("R5 R6 D0 status", mem[(BASE + 'h00) / 4], exp_stat(70, 100, 0));
        check_buf("R4 D0 bytes", 'h102, 70, 100);
        check("R6 R7 D1 status", mem[(BASE + 'h10) / 4], exp_stat(33, 20, 0));
        check_buf("R7 D1 truncated", 'h202, 33, 20);
        check("R8 D2 rejected", mem[(BASE + 'h20) / 4], 32'h0004_0000);
        check("R8 D2 buffer untouched", {24'd0, get_byte('h300)}, 32'h000000A5);
        check("R7 D3 status", mem[(BASE + 'h30) / 4], exp_stat(10, 100, 1));
        check_buf("R4 D3 bytes", 'h402, 10, 100);
        check("R9 wrap to base", {31'd0, rx_nobuf}, 32'd1);
        check("R9 decoy unused", mem[(BASE + 'h40) / 4], 32'h8000_0000);

        // R3: frame while stalled is dropped
        send_frame(12, 0);
        repeat (5) @(negedge clk);
        check("R3 nobuf held", {31'd0, rx_nobuf}, 32'd1);
        check("R3 D0 unchanged", mem[(BASE + 'h00) / 4], exp_stat(70, 100, 0));
        check("R3 buffer unchanged", {24'd0, get_byte('h102)}, {24'd0, fbyte(70, 0)});

        // sweep of frame lengths across runt and buffer-size limits
        for (int g = 0; g < 20; g++) begin
            fill('h100, 'h500);
            for (int k = 0; k < 4; k++)
                set_desc(BASE + 16 * k, 1, k == 3, 64, 'h102 + 'h100 * k);
            do_poll();
            for (int k = 0; k < 4; k++) begin
                int len;
                len = g * 4 + k + 1;
                send_frame(len, len % 4 == 0);
            end
            repeat (10) @(negedge clk);
            for (int k = 0; k < 4; k++) begin
                int len;
                len = g * 4 + k + 1;
                check("R5 R6 R7 sweep status", mem[(BASE + 16 * k) / 4], exp_stat(len, 64, len % 4 == 0));
                check_buf("R4 R7 sweep bytes", 'h102 + 'h100 * k, len, 64);
            end
            check("R9 sweep wrap", {31'd0, rx_nobuf}, 32'd1);
        end

        // R3: manual poll releases the stall for one fetch
        do_poll();
        check("R3 nobuf drops after poll", {31'd0, rx_nobuf}, 32'd0);
        repeat (6) @(negedge clk);
        check("R3 stalled again", {31'd0, rx_nobuf}, 32'd1);

        // R10: automatic poll interval
        for (int n = 1; n <= 3; n++) begin
            int cnt;
            poll_ivl = 4'(n);
            while (rx_nobuf) @(negedge clk);
            while (!rx_nobuf) @(negedge clk);
            cnt = 0;
            while (rx_nobuf) begin
                cnt++;
                @(negedge clk);
            end
            check("R10 auto poll interval", 32'(cnt), 32'(n * TICK));
        end
        while (!rx_nobuf) @(negedge clk);
        poll_ivl = 4'd0;
        begin
            int drops;
            drops = 0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (!rx_nobuf) drops++;
            end
            check("R10 interval zero never polls", 32'(drops), 32'd0);
        end
        summary();
    end
endmodule